// File: doc/BRIEF.md
# Chainable Line Capture Register for a Column Driver

This block gathers one horizontal line of 6-bit gray-scale codes for a column driver that sits in a chain of identical drivers. Each rising clock edge can deliver a word of six codes. Capture begins when a start pulse arrives on whichever chain pin the direction input names as the input. The block then loads one six-code group per clock into a line register. Depending on direction, the groups fill from the first column upward or from the last column downward. Two control bits can invert the lower or upper three codes of each word as it is loaded.

A fixed number of clocks after its own start, the block drives a one-clock pulse on the other chain pin, which becomes the start for the next driver. It keeps its capture window open for a few more clocks and then goes idle by itself. A rising edge on the strobe input ends capture at once. The line register stays valid between captures and feeds the conversion stage, which is not part of this block.

Top module: `col_line_capture`

## Requirements
- R1: A synchronous active-low reset clears every code of the line register to zero, drives both chain outputs low and leaves the block idle.
- R2: The start input is sampled on the rising clock edge. The edge that sees it high loads nothing. The next GROUPS edges load groups 0, 1, ..., GROUPS-1, one word per edge.
- R3: With the direction input high, group g is stored in slot g. Port k of the word (bits [6k+5:6k], bit 0 the LSB) lands in column 6g+k+1, which is line_o bits [(6g+k)*6+5:(6g+k)*6].
- R4: With the direction input low, group g is stored in slot GROUPS-1-g, so the first word fills the highest columns. Within a slot the port-to-column mapping is the same as in R3.
- R5: The direction level sampled at the start edge picks the roles of the chain pins. High means the right pin is the start input and the left pin is the chain output; low swaps the two. A pulse on the pin that is not the input is ignored. The unused output stays low, and the two outputs are never high together.
- R6: The chain output is high for exactly one clock. It rises after the TOKEN_AT-th rising edge that follows the start edge.
- R7: Capture stays open until STOP_AT edges after the start edge and then closes by itself. Words presented after group GROUPS-1 leave the line register unchanged.
- R8: When inv_lo_i is high, the codes on ports 0 to 2 are stored bitwise inverted. When inv_hi_i is high, ports 3 to 5 are stored inverted. Both controls are sampled on the same edge as the word.
- R9: A rising strobe edge ends capture on that edge. Neither that word nor any later word is stored, no chain pulse follows, and the stored codes are kept. If a strobe rise and a start arrive on the same edge, the strobe rise wins.
- R10: A start that arrives while capture is open restarts capture at group 0. The chain pulse timing is counted from the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_right | input | 1 | Direction: 1 = right pin in, forward fill; 0 = left pin in, reverse fill |
| chain_r_i | input | 1 | Right-side chain start input |
| chain_l_i | input | 1 | Left-side chain start input |
| chain_r_o | output | 1 | Right-side chain start output (driven when direction is low) |
| chain_l_o | output | 1 | Left-side chain start output (driven when direction is high) |
| strobe_i | input | 1 | Line strobe; its rising edge ends capture |
| inv_lo_i | input | 1 | Invert codes on ports 0 to 2 at load |
| inv_hi_i | input | 1 | Invert codes on ports 3 to 5 at load |
| pix_i | input | PORTS*CODE_W | Six input codes, port k in bits [6k+5:6k] |
| line_o | output | GROUPS*PORTS*CODE_W | Captured line, column c in bits [6c-1:6c-6] |

## Verification
The bench builds the block with GROUPS=5, TOKEN_AT=5 and STOP_AT=7, keeping six ports of six bits. With that line length, every direction can be combined with every inversion setting in a few dozen clocks. Every slot of the line can be compared against arithmetic codes after each run. The short window also puts the chain-pulse clock and the gap between the last stored group and auto-stop close to the start edge. This makes restarts, strobe aborts and same-edge strobe-and-start cheap to place at exact clock offsets.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
   // Fill order of the six-code groups across the line.
   typedef enum logic [0:0] {
      FILL_REV = 1'b0,
      FILL_FWD = 1'b1
   } fill_dir_e;
endpackage

// File: rtl/dcap_seq.sv
// Capture sequencer: start/strobe handling, group pointer, chain pulse.
module dcap_seq #(
   parameter int GROUPS   = 70,
   parameter int TOKEN_AT = 70,
   parameter int STOP_AT  = 72,
   localparam int CNT_W   = $clog2(STOP_AT + 1),
   localparam int GRP_W   = $clog2(GROUPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             dir_i,
   input  logic             strobe_i,
   output logic             wr_en_o,
   output logic [GRP_W-1:0] wr_slot_o,
   output logic             tok_o,
   output logic             fwd_o
);
   import dcap_pkg::*;

   logic [CNT_W-1:0] cnt_q;
   logic             strobe_q;
   logic             tok_q;
   fill_dir_e        fill_q;
   logic             strobe_rise;
   logic [GRP_W-1:0] grp;

   assign strobe_rise = strobe_i & ~strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
         tok_q    <= 1'b0;
         fill_q   <= FILL_FWD;
      end else begin
         strobe_q <= strobe_i;
         tok_q    <= 1'b0;
         if (strobe_rise) begin
            cnt_q <= '0;
         end else if (start_i) begin
            cnt_q  <= CNT_W'(1);
            fill_q <= fill_dir_e'(dir_i);
         end else if (cnt_q != '0) begin
            cnt_q <= (cnt_q == CNT_W'(STOP_AT)) ? '0 : cnt_q + CNT_W'(1);
            tok_q <= (cnt_q == CNT_W'(TOKEN_AT));
         end
      end
   end

   assign grp       = GRP_W'(cnt_q - CNT_W'(1));
   assign wr_en_o   = (cnt_q != '0) && (cnt_q <= CNT_W'(GROUPS)) && !strobe_rise && !start_i;
   assign wr_slot_o = (fill_q == FILL_FWD) ? grp : GRP_W'(GROUPS - 1) - grp;
   assign tok_o     = tok_q;
   assign fwd_o     = (fill_q == FILL_FWD);

   AST_TOKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_q |=> !tok_q); // R6
   AST_STROBE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_i) |=> (cnt_q == '0) && !tok_q); // R9
   AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(STOP_AT)) && !start_i |=> (cnt_q == '0)); // R7
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !strobe_i |=> (cnt_q == CNT_W'(1))); // R10
endmodule

// File: rtl/dcap_inv.sv
// Per-half-port load inversion.
module dcap_inv #(
   parameter int PORTS  = 6,
   parameter int CODE_W = 6,
   localparam int WORD_W = PORTS * CODE_W
) (
   input  logic              inv_lo_i,
   input  logic              inv_hi_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   if (PORTS % 2 != 0) begin : g_bad_ports
      $error("dcap_inv: PORTS must be even");
   end

   for (genvar k = 0; k < PORTS; k++) begin : g_port
      if (k < PORTS / 2) begin : g_lo
         assign word_o[k*CODE_W +: CODE_W] = word_i[k*CODE_W +: CODE_W] ^ {CODE_W{inv_lo_i}};
      end else begin : g_hi
         assign word_o[k*CODE_W +: CODE_W] = word_i[k*CODE_W +: CODE_W] ^ {CODE_W{inv_hi_i}};
      end
   end
endmodule

// File: rtl/dcap_line.sv
// Line register: one word-wide slot per group.
module dcap_line #(
   parameter int GROUPS = 70,
   parameter int PORTS  = 6,
   parameter int CODE_W = 6,
   localparam int WORD_W = PORTS * CODE_W,
   localparam int GRP_W  = $clog2(GROUPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic [GRP_W-1:0]         wr_slot_i,
   input  logic [WORD_W-1:0]        word_i,
   output logic [GROUPS*WORD_W-1:0] line_o
);
   logic [GROUPS-1:0][WORD_W-1:0] line_q;

   for (genvar s = 0; s < GROUPS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            line_q[s] <= '0;
         else if (wr_en_i && (wr_slot_i == GRP_W'(s)))
            line_q[s] <= word_i;
      end
   end

   assign line_o = line_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(line_q)); // R7
endmodule

// File: rtl/col_line_capture.sv
// Top: chainable line capture for a column driver.
module col_line_capture #(
   parameter int GROUPS   = 70,
   parameter int PORTS    = 6,
   parameter int CODE_W   = 6,
   parameter int TOKEN_AT = 70,
   parameter int STOP_AT  = 72,
   localparam int WORD_W  = PORTS * CODE_W,
   localparam int LINE_W  = GROUPS * WORD_W,
   localparam int GRP_W   = $clog2(GROUPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_right,
   input  logic              chain_r_i,
   input  logic              chain_l_i,
   output logic              chain_r_o,
   output logic              chain_l_o,
   input  logic              strobe_i,
   input  logic              inv_lo_i,
   input  logic              inv_hi_i,
   input  logic [WORD_W-1:0] pix_i,
   output logic [LINE_W-1:0] line_o
);
   if (GROUPS < 2) begin : g_bad_groups
      $error("col_line_capture: GROUPS must be at least 2");
   end
   if (TOKEN_AT > STOP_AT || GROUPS > STOP_AT || TOKEN_AT < 1) begin : g_bad_window
      $error("col_line_capture: need 1 <= TOKEN_AT <= STOP_AT and GROUPS <= STOP_AT");
   end

   logic             start_sel;
   logic             wr_en;
   logic [GRP_W-1:0] wr_slot;
   logic             tok;
   logic             fwd;
   logic [WORD_W-1:0] word_ld;

   assign start_sel = dir_right ? chain_r_i : chain_l_i;

   dcap_seq #(.GROUPS(GROUPS), .TOKEN_AT(TOKEN_AT), .STOP_AT(STOP_AT)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_sel),
      .dir_i     (dir_right),
      .strobe_i  (strobe_i),
      .wr_en_o   (wr_en),
      .wr_slot_o (wr_slot),
      .tok_o     (tok),
      .fwd_o     (fwd)
   );

   dcap_inv #(.PORTS(PORTS), .CODE_W(CODE_W)) i_inv (
      .inv_lo_i (inv_lo_i),
      .inv_hi_i (inv_hi_i),
      .word_i   (pix_i),
      .word_o   (word_ld)
   );

   dcap_line #(.GROUPS(GROUPS), .PORTS(PORTS), .CODE_W(CODE_W)) i_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_slot_i (wr_slot),
      .word_i    (word_ld),
      .line_o    (line_o)
   );

   assign chain_l_o = tok & fwd;
   assign chain_r_o = tok & ~fwd;

   AST_ONE_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chain_r_o, chain_l_o})); // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !chain_r_o && !chain_l_o); // R1
endmodule

// File: tb/test_col_line_capture.sv
module test_col_line_capture;
   localparam int G  = 5;
   localparam int P  = 6;
   localparam int CW = 6;
   localparam int TK = 5;
   localparam int ST = 7;
   localparam int NC = G * P;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            dir_right = 1'b1;
   logic            chain_r_i = 1'b0, chain_l_i = 1'b0;
   logic            chain_r_o, chain_l_o;
   logic            strobe_i = 1'b0, inv_lo_i = 1'b0, inv_hi_i = 1'b0;
   logic [P*CW-1:0] pix_i = '0;
   logic [NC*CW-1:0] line_o;

   int n_run = 0;
   int n_fail = 0;
   logic [5:0] exp_c [NC];

   col_line_capture #(.GROUPS(G), .PORTS(P), .CODE_W(CW), .TOKEN_AT(TK), .STOP_AT(ST))
   i_col_line_capture (
      .clk(clk), .rst_n(rst_n), .dir_right(dir_right),
      .chain_r_i(chain_r_i), .chain_l_i(chain_l_i),
      .chain_r_o(chain_r_o), .chain_l_o(chain_l_o),
      .strobe_i(strobe_i), .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i),
      .pix_i(pix_i), .line_o(line_o)
   );

   function automatic logic [5:0] code_of(int seed, int g, int k);
      return 6'((seed + 11 * g + 5 * k) & 63);
   endfunction

   task automatic chk(bit ok, string rq, int act, int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
      end
   endtask

   task automatic check_line(string rq);
      int bad = -1;
      for (int c = 0; c < NC; c++)
         if (line_o[c*6 +: 6] !== exp_c[c] && bad < 0) bad = c;
      if (bad < 0) chk(1'b1, rq, 0, 0);
      else begin
         $display("  column %0d differs", bad + 1);
         chk(1'b0, rq, int'(line_o[bad*6 +: 6]), int'(exp_c[bad]));
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   // Present group g; when upd is set, record what the line should hold.
   task automatic drive_group(int seed, int g, bit il, bit ih, bit fwd, bit upd);
      int slot = fwd ? g : G - 1 - g;
      inv_lo_i = il;
      inv_hi_i = ih;
      for (int k = 0; k < P; k++) begin
         pix_i[k*6 +: 6] = code_of(seed, g, k);
         if (upd) exp_c[slot*P + k] = code_of(seed, g, k) ^ (((k < 3) ? il : ih) ? 6'h3f : 6'h00);
      end
   endtask

   task automatic check_quiet(string rq);
      chk(!chain_r_o && !chain_l_o, rq, int'({chain_r_o, chain_l_o}), 0);
   endtask

   task automatic run_line(bit fwd, bit il, bit ih, int seed);
      dir_right = fwd;
      if (fwd) chain_r_i = 1'b1; else chain_l_i = 1'b1;
      tick;                                   // start edge, stores nothing (R2)
      chain_r_i = 1'b0;
      chain_l_i = 1'b0;
      for (int i = 1; i <= ST + 2; i++) begin
         if (i <= G) drive_group(seed, i - 1, il, ih, fwd, 1'b1);
         else drive_group(seed + 29 * i, i, ~il, ~ih, fwd, 1'b0); // junk beyond the line (R7)
         tick;
         // R6 pulse on the output pin chosen by direction, R5 other pin low
         chk(((fwd ? chain_l_o : chain_r_o) == (i == TK)) && !(fwd ? chain_r_o : chain_l_o),
             "R6 chain pulse timing", int'({chain_r_o, chain_l_o}), (i == TK) ? (fwd ? 1 : 2) : 0);
      end
      check_line(fwd ? "R3/R8/R7 forward line" : "R4/R8/R7 reverse line");
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) exp_c[c] = '0;
      @(negedge clk);
      tick; tick; tick;
      check_line("R1 reset line");
      check_quiet("R1 reset chain outputs");
      rst_n = 1'b1;
      tick;

      // Sweep both directions with every inversion setting (R2, R3, R4, R8)
      for (int d = 0; d < 2; d++)
         for (int m = 0; m < 4; m++)
            run_line(d[0], m[0], m[1], 7 + 13 * (d * 4 + m));

      // R5: pulse on the non-input pin is ignored
      dir_right = 1'b1;
      chain_l_i = 1'b1;
      tick;
      chain_l_i = 1'b0;
      for (int i = 1; i <= ST + 1; i++) begin
         drive_group(99, i % G, 1'b0, 1'b0, 1'b1, 1'b0);
         tick;
         check_quiet("R5 wrong start pin");
      end
      check_line("R5 wrong pin leaves line");

      // R9: strobe rise mid-capture stops it; later data and the pulse never come
      dir_right = 1'b1;
      chain_r_i = 1'b1;
      tick;
      chain_r_i = 1'b0;
      for (int i = 1; i <= ST + 2; i++) begin
         drive_group(200, (i - 1) % G, 1'b0, 1'b1, 1'b1, i <= 2);
         strobe_i = (i == 3);
         tick;
         check_quiet("R9 no pulse after strobe");
      end
      check_line("R9 strobe abort keeps line");

      // R9: strobe rise and start on the same edge, strobe wins
      strobe_i = 1'b1;
      chain_r_i = 1'b1;
      tick;
      strobe_i = 1'b0;
      chain_r_i = 1'b0;
      for (int i = 1; i <= ST + 1; i++) begin
         drive_group(300, (i - 1) % G, 1'b1, 1'b0, 1'b1, 1'b0);
         tick;
         check_quiet("R9 strobe beats start");
      end
      check_line("R9 same-edge start ignored");

      // R10: restart while capture is open
      dir_right = 1'b0;
      chain_l_i = 1'b1;
      tick;
      chain_l_i = 1'b0;
      for (int i = 1; i <= 3; i++) begin
         drive_group(400, i - 1, 1'b0, 1'b0, 1'b0, 1'b1);
         tick;
         check_quiet("R10 no pulse before restart");
      end
      check_line("R10 partial line before restart");
      run_line(1'b0, 1'b1, 1'b0, 450);       // pulse timing counted from new start

      // R1: reset after activity clears the line
      rst_n = 1'b0;
      tick;
      rst_n = 1'b1;
      for (int c = 0; c < NC; c++) exp_c[c] = '0;
      check_line("R1 reset clears line");
      check_quiet("R1 reset after activity");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule